// File: doc/BRIEF.md
# Two-Port Byte Mailbox Host Interface

This block sits on the device side of a small host-facing mailbox. It has two byte-wide host ports. A data port sits at offset 0. A shared command/status port sits at offset 1: a write there is a command and a read there returns the status byte. The host frames every request with an open command (0x01) and a close command (0x03). It moves payload through the data port one byte at a time and paces itself on the status flags. A cancel command (0x22) can be written at any time and returns everything to idle.

Toward the device, accepted host bytes leave on a valid/ready receive stream, with a flag that tells command bytes from data bytes. `rx_valid` holds, with its byte, until `rx_ready` is seen high at a clock edge. Response payload comes in on a valid/ready transmit stream. A byte moves only in a cycle where both `tx_valid` and `tx_ready` are high. `tx_ready` falls when the internal response queue is full, or in the cycle a cancel is written.

The block wraps every response for the host. It emits a leading 0x01 with the F0 flag set, then the payload bytes with F0 clear, then a trailing 0x03 with F0 set after the byte that carried `tx_last`. Each byte waits in an output latch until the host reads the data port.

Top module: `mbox_host_if`

## Requirements
- R1: Status byte layout: bit0 output-buffer-full, bit1 input-buffer-full, bit2 F0 (the latched output byte is a framing byte), bit3 A2, bit4 ready-for-command, bit5 ready-for-data, bits 7:6 zero. After reset the status reads 0x10. Reading the status port has no side effect.
- R2: Any non-cancel host write to offset 0 or 1 is accepted only while input-buffer-full is clear. It latches the byte, sets input-buffer-full and presents the byte on the receive stream with `rx_cmd` = 1 for offset 1. A write made while input-buffer-full is set is dropped.
- R3: Input-buffer-full and `rx_valid` read clear in the cycle after a receive handshake. Until that handshake, `rx_valid` and `rx_data` hold steady.
- R4: An accepted 0x01 command opens a message: ready-for-data (bit5) sets and ready-for-command (bit4) drops. An accepted 0x03 command closes the message. Ready-for-command reads 1 only with no open message and input-buffer-full clear. A data write while no message is open is dropped.
- R5: A2 is 1 when the last accepted write went to the command port and 0 when it went to the data port. Dropped writes leave A2 unchanged.
- R6: Each response is read as 0x01 with F0 set, then every payload byte in order with F0 clear, then 0x03 with F0 set.
- R7: Output-buffer-full set means a byte is waiting on the data port, and the byte holds until it is read. A data-port read loads the next framed byte in the same edge, or clears output-buffer-full and F0 when none is pending.
- R8: A cancel write flushes the input latch, the output latch and all queued response bytes. It closes any message, is not forwarded to the device, and makes the status read exactly 0x10 on the next cycle.
- R9: The transmit stream takes a byte only when `tx_valid` and `tx_ready` are both high. `tx_ready` is low while the response queue holds DEPTH bytes, and an offered byte is not taken then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_cs | input | 1 | Host access strobe, one cycle per access |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 1 | 0 = data port, 1 = command/status port |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Read byte: status at offset 1, output latch at offset 0 |
| rx_valid | output | 1 | Received host byte available |
| rx_ready | input | 1 | Device takes the received byte |
| rx_data | output | 8 | Received byte |
| rx_cmd | output | 1 | Received byte came from the command port |
| tx_valid | input | 1 | Device offers a response byte |
| tx_ready | output | 1 | Response byte accepted this cycle |
| tx_data | input | 8 | Response payload byte |
| tx_last | input | 1 | Marks the final payload byte of a response |

## Verification
A host write or cancel is visible in the status byte and on the receive stream in the cycle after its clock edge. A receive handshake clears input-buffer-full one edge later. The first response byte reaches the output latch one edge after it enters the queue, as the leading 0x01. Each data-port read swaps in the next byte at that same edge. The bench drives each access in the half cycle before an edge and releases it just after. It checks flags at the following falling edge, and it waits two extra cycles before the first check of a response, so every check falls where the result is already due.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CODE_OPEN  = 8'h01;
  localparam logic [BYTE_W-1:0] CODE_CLOSE = 8'h03;
  localparam logic [BYTE_W-1:0] CODE_ABORT = 8'h22;

  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_F0  = 2;
  localparam int ST_A2  = 3;
  localparam int ST_RDY = 4;
  localparam int ST_IBR = 5;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_BODY = 2'd1,
    RS_TAIL = 2'd2
  } resp_state_t;
endpackage

// File: rtl/mbox_rx_stage.sv
module mbox_rx_stage
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              wr_is_cmd,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              abort,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_cmd,
  output logic              ibf,
  output logic              ibr,
  output logic              rdy,
  output logic              a2
);
  logic              ibf_q, cmd_q, a2_q, open_q;
  logic [BYTE_W-1:0] dat_q;
  logic              accept;

  assign accept = wr_stb && !ibf_q && (wr_is_cmd || open_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q  <= 1'b0;
      cmd_q  <= 1'b0;
      a2_q   <= 1'b0;
      open_q <= 1'b0;
      dat_q  <= '0;
    end else if (abort) begin
      ibf_q  <= 1'b0;
      cmd_q  <= 1'b0;
      a2_q   <= 1'b0;
      open_q <= 1'b0;
    end else if (accept) begin
      ibf_q <= 1'b1;
      dat_q <= wr_byte;
      cmd_q <= wr_is_cmd;
      a2_q  <= wr_is_cmd;
      if (wr_is_cmd && wr_byte == CODE_OPEN)       open_q <= 1'b1;
      else if (wr_is_cmd && wr_byte == CODE_CLOSE) open_q <= 1'b0;
    end else if (ibf_q && rx_ready) begin
      ibf_q <= 1'b0;
    end
  end

  assign rx_valid = ibf_q;
  assign rx_data  = dat_q;
  assign rx_cmd   = cmd_q;
  assign ibf      = ibf_q;
  assign ibr      = open_q;
  assign rdy      = !open_q && !ibf_q;
  assign a2       = a2_q;

  AST_IBF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !wr_stb) |=> !ibf); // R3
  AST_RX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !abort) |=> (rx_valid && $stable(rx_data))); // R3
  AST_OPEN_SETS_IBR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_is_cmd && !ibf && wr_byte == CODE_OPEN && !abort) |=> (ibr && !rdy)); // R4
endmodule

// File: rtl/mbox_tx_fifo.sv
module mbox_tx_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  assign pop_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push && !full)  wptr <= bump(wptr);
      if (pop && !empty)  rptr <= bump(rptr);
      case ({push && !full, pop && !empty})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R7
endmodule

// File: rtl/mbox_tx_framer.sv
module mbox_tx_framer
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              host_pop,
  input  logic              q_empty,
  input  logic [BYTE_W-1:0] q_byte,
  input  logic              q_last,
  output logic              q_pop,
  output logic              obf,
  output logic              f0,
  output logic [BYTE_W-1:0] olat
);
  resp_state_t       st_q, st_d;
  logic              obf_q, f0_q, can_load, load, ld_f0;
  logic [BYTE_W-1:0] lat_q, ld_byte;

  assign can_load = (!obf_q || host_pop) && !abort;

  always_comb begin
    st_d    = st_q;
    load    = 1'b0;
    ld_byte = q_byte;
    ld_f0   = 1'b0;
    q_pop   = 1'b0;
    if (can_load) begin
      case (st_q)
        RS_IDLE: if (!q_empty) begin
          load = 1'b1; ld_byte = CODE_OPEN; ld_f0 = 1'b1; st_d = RS_BODY;
        end
        RS_BODY: if (!q_empty) begin
          load = 1'b1; q_pop = 1'b1;
          if (q_last) st_d = RS_TAIL;
        end
        RS_TAIL: begin
          load = 1'b1; ld_byte = CODE_CLOSE; ld_f0 = 1'b1; st_d = RS_IDLE;
        end
        default: st_d = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RS_IDLE;
      obf_q <= 1'b0;
      f0_q  <= 1'b0;
      lat_q <= '0;
    end else if (abort) begin
      st_q  <= RS_IDLE;
      obf_q <= 1'b0;
      f0_q  <= 1'b0;
    end else if (load) begin
      st_q  <= st_d;
      obf_q <= 1'b1;
      f0_q  <= ld_f0;
      lat_q <= ld_byte;
    end else if (host_pop) begin
      obf_q <= 1'b0;
      f0_q  <= 1'b0;
    end
  end

  assign obf  = obf_q;
  assign f0   = f0_q;
  assign olat = lat_q;

  AST_OBF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (obf && !host_pop && !abort) |=> (obf && $stable(olat) && $stable(f0))); // R7
  AST_F0_NEEDS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    f0 |-> obf); // R6
endmodule

// File: rtl/mbox_host_if.sv
module mbox_host_if
  import mbox_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hst_cs,
  input  logic       hst_we,
  input  logic       hst_addr,
  input  logic [7:0] hst_wdata,
  output logic [7:0] hst_rdata,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_cmd,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  input  logic       tx_last
);
  localparam int QW = BYTE_W + 1;

  logic          host_wr, abort, wr_stb, host_pop;
  logic          ibf, ibr, rdy, a2, obf, f0;
  logic [7:0]    olat, status;
  logic          q_push, q_pop, q_empty, q_full;
  logic [QW-1:0] q_out;

  assign host_wr  = hst_cs && hst_we;
  assign abort    = host_wr && hst_addr && (hst_wdata == CODE_ABORT);
  assign wr_stb   = host_wr && !abort;
  assign host_pop = hst_cs && !hst_we && !hst_addr;
  assign tx_ready = !q_full && !abort;
  assign q_push   = tx_valid && tx_ready;

  mbox_rx_stage u_rx (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_is_cmd(hst_addr),
    .wr_byte(hst_wdata), .abort(abort), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_cmd(rx_cmd),
    .ibf(ibf), .ibr(ibr), .rdy(rdy), .a2(a2)
  );

  mbox_tx_fifo #(.W(QW), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .flush(abort), .push(q_push),
    .push_data({tx_last, tx_data}), .pop(q_pop), .pop_data(q_out),
    .empty(q_empty), .full(q_full)
  );

  mbox_tx_framer u_fr (
    .clk(clk), .rst_n(rst_n), .abort(abort), .host_pop(host_pop),
    .q_empty(q_empty), .q_byte(q_out[BYTE_W-1:0]), .q_last(q_out[BYTE_W]),
    .q_pop(q_pop), .obf(obf), .f0(f0), .olat(olat)
  );

  always_comb begin
    status         = '0;
    status[ST_OBF] = obf;
    status[ST_IBF] = ibf;
    status[ST_F0]  = f0;
    status[ST_A2]  = a2;
    status[ST_RDY] = rdy;
    status[ST_IBR] = ibr;
  end

  assign hst_rdata = hst_addr ? status : olat;

  AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (status == 8'h10 && !rx_valid)); // R8
  AST_WRITE_SETS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && hst_addr && !ibf) |=> (ibf && rx_cmd)); // R2
  AST_STATUS_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_cs && hst_addr && !hst_we) |-> (hst_rdata[7:6] == 2'b00)); // R1
endmodule

// File: tb/test_mbox_host_if.sv
module test_mbox_host_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hst_cs = 1'b0, hst_we = 1'b0, hst_addr = 1'b0;
  logic [7:0] hst_wdata = '0;
  logic [7:0] hst_rdata;
  logic       rx_valid, rx_cmd, tx_ready;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       tx_valid = 1'b0, tx_last = 1'b0;
  logic [7:0] tx_data = '0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mbox_host_if i_mbox_host_if (
    .clk(clk), .rst_n(rst_n), .hst_cs(hst_cs), .hst_we(hst_we),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_cmd(rx_cmd), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    hst_cs = 1'b1; hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(posedge clk); #1;
    hst_cs = 1'b0; hst_we = 1'b0;
  endtask

  task automatic host_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    hst_cs = 1'b1; hst_we = 1'b0; hst_addr = a;
    #2 d = hst_rdata;
    @(posedge clk); #1;
    hst_cs = 1'b0;
  endtask

  task automatic expect_status(input string tag, input logic [7:0] exp);
    logic [7:0] s;
    host_read(1'b1, s);
    check(tag, s, exp);
  endtask

  task automatic expect_data(input string tag, input logic [7:0] exp);
    logic [7:0] d;
    host_read(1'b0, d);
    check(tag, d, exp);
  endtask

  task automatic dev_take();
    @(negedge clk); rx_ready = 1'b1;
    @(posedge clk); #1; rx_ready = 1'b0;
  endtask

  task automatic dev_push(input logic [7:0] d, input logic l);
    @(negedge clk); tx_valid = 1'b1; tx_data = d; tx_last = l;
    @(posedge clk); #1; tx_valid = 1'b0; tx_last = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset rx_valid", {7'd0, rx_valid}, 8'h00);
    check("R9 reset tx_ready", {7'd0, tx_ready}, 8'h01);
    expect_status("R1 reset status", 8'h10);
  endtask

  task automatic t_send_message();
    host_write(1'b1, 8'h01);
    check("R2 open rx_valid", {7'd0, rx_valid}, 8'h01);
    check("R2 open rx_data", rx_data, 8'h01);
    check("R2 open rx_cmd", {7'd0, rx_cmd}, 8'h01);
    expect_status("R4 R5 open status", 8'h2A);
    host_write(1'b0, 8'h55);
    check("R2 dropped write keeps rx_data", rx_data, 8'h01);
    expect_status("R5 dropped write keeps A2", 8'h2A);
    dev_take();
    check("R3 rx_valid after take", {7'd0, rx_valid}, 8'h00);
    expect_status("R3 IBF clear", 8'h28);
    host_write(1'b0, 8'hA5);
    check("R2 data rx_data", rx_data, 8'hA5);
    check("R2 data rx_cmd", {7'd0, rx_cmd}, 8'h00);
    expect_status("R5 data write A2 low", 8'h22);
    dev_take();
    host_write(1'b1, 8'h03);
    check("R2 close rx_data", rx_data, 8'h03);
    dev_take();
    expect_status("R4 closed status", 8'h18);
  endtask

  task automatic t_stray_data();
    host_write(1'b0, 8'h77);
    check("R4 stray data rx_valid", {7'd0, rx_valid}, 8'h00);
    expect_status("R4 stray data status", 8'h18);
  endtask

  task automatic t_response();
    dev_push(8'h11, 1'b0);
    dev_push(8'h22, 1'b1);
    repeat (2) @(posedge clk);
    expect_status("R7 head ready", 8'h1D);
    expect_data("R6 head byte", 8'h01);
    expect_status("R6 payload F0 clear", 8'h19);
    expect_data("R6 payload 0", 8'h11);
    expect_data("R6 payload 1", 8'h22);
    expect_status("R6 tail F0 set", 8'h1D);
    expect_data("R6 tail byte", 8'h03);
    expect_status("R7 OBF clear after tail", 8'h18);
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < 4; i++) dev_push(8'hB0 + 8'(i), i == 3);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = 8'hEE; tx_last = 1'b1;
    #1 check("R9 tx_ready low when full", {7'd0, tx_ready}, 8'h00);
    repeat (2) @(posedge clk);
    #1 tx_valid = 1'b0; tx_last = 1'b0;
    expect_data("R9 head", 8'h01);
    for (int i = 0; i < 4; i++) expect_data("R9 queued byte", 8'hB0 + 8'(i));
    expect_data("R9 tail", 8'h03);
    expect_status("R9 refused byte absent", 8'h18);
  endtask

  task automatic t_cancel();
    host_write(1'b1, 8'h01);
    dev_push(8'h5A, 1'b1);
    repeat (2) @(posedge clk);
    expect_status("R8 busy before cancel", 8'h2F);
    host_write(1'b1, 8'h22);
    check("R8 rx_valid dropped", {7'd0, rx_valid}, 8'h00);
    expect_status("R8 status after cancel", 8'h10);
    repeat (3) @(posedge clk);
    expect_status("R8 response flushed", 8'h10);
    check("R8 tx_ready back", {7'd0, tx_ready}, 8'h01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_send_message();
    t_stray_data();
    t_response();
    t_backpressure();
    t_cancel();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule